// File: doc/BRIEF.md
# Hardware Timestamp Event Capture Unit

This block keeps a free-running time counter on the reference clock and records the counter value each time a time-synchronisation event happens. The event sources are eight generic hardware push inputs, Ethernet receive and transmit strobes, a host transmit strobe and a software push request. The counter also raises its own events when its top bit rises (half-rollover) and when it wraps (rollover). Every captured event is stored with a type code, a source index and the timestamp in a small queue. A host reads the queue through a simple pop-style read port.

The counter normally advances by one per clock. A rate trim adds a fractional value to an accumulator, either on every clock (parts-per-million mode) or once every 3600 clocks (parts-per-hour mode). Each accumulator carry adds one extra count, or withholds one count when the trim sign is negative. Events that cannot be stored set a sticky overflow flag, which the host clears with a write strobe.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset the counter is 0, the trim accumulator and divider are 0, the queue is empty (rd_valid_o low) and ovf_o is low.
- R2: With trim_frac_i at 0 the counter rises by exactly one per clock, and wraps modulo 2^CNT_W.
- R3: In ppm mode (trim_pph_i=0), trim_frac_i is added on each clock to a FRAC_W-bit accumulator. On a carry out, the counter step that clock is 2 if trim_neg_i=0, or 0 if trim_neg_i=1. Otherwise the step is 1.
- R4: In pph mode (trim_pph_i=1), the accumulator only advances on clocks where a free-running divider, counting 0 to PPH_DIV-1, is at PPH_DIV-1. Only those clocks can alter the step.
- R5: A rising edge on hw_push_i[n] creates one event with type 0 and source n. Holding the input high creates no further events. The timestamp is the counter value in the cycle the high level is first sampled.
- R6: Each cycle in which eth_rx_i, eth_tx_i, host_tx_i or sw_push_i is high creates one event, with type 1, 2, 3 or 4 respectively and source 0. The timestamp is the counter value in that cycle.
- R7: The first cycle in which the counter's top bit reads 1 after reading 0 creates a half-rollover event (type 6). The first cycle in which it reads 0 after reading 1 creates a rollover event (type 5). Both carry source 0 and that cycle's counter value.
- R8: Events raised in the same cycle enter the queue in this order: hardware push 0 to 7, receive, transmit, host transmit, software push, rollover, half-rollover. One event is queued per clock.
- R9: rd_valid_o is high exactly while the queue holds an entry. The oldest entry is shown on rd_type_o, rd_src_o and rd_stamp_o. rd_pop_i removes it. An event sampled at one clock edge can be seen at the read port after the next edge.
- R10: The queue holds FIFO_DEPTH entries. An event chosen for queuing while the queue is full is discarded and ovf_o is set.
- R11: If a source fires again while its previous capture is still waiting to be queued, the new capture is discarded and ovf_o is set.
- R12: ovf_o stays set until a cycle with ovf_clr_i high and no new discard. A discard in the same cycle as the clear leaves it set.
- R13: rd_pop_i while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_push_i | input | NUM_HW | Generic hardware push inputs, rising-edge sensitive |
| eth_rx_i | input | 1 | Ethernet receive strobe |
| eth_tx_i | input | 1 | Ethernet transmit strobe |
| host_tx_i | input | 1 | Host transmit strobe |
| sw_push_i | input | 1 | Software timestamp request |
| trim_pph_i | input | 1 | 0: trim per clock, 1: trim once per PPH_DIV clocks |
| trim_neg_i | input | 1 | 1: accumulator carry removes a count |
| trim_frac_i | input | FRAC_W | Fractional trim increment |
| rd_pop_i | input | 1 | Remove the oldest queued event |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| rd_valid_o | output | 1 | Queue not empty |
| rd_type_o | output | 4 | Event type of oldest entry |
| rd_src_o | output | $clog2(NUM_HW) | Source index of oldest entry |
| rd_stamp_o | output | CNT_W | Timestamp of oldest entry |
| ovf_o | output | 1 | Sticky event-loss flag |

## Verification
The bench runs a 12-bit counter. Over a few thousand cycles, the counter crosses its half point and its wrap point, so both self-generated events appear among software push captures. A single push after reset, with the trim off, pins the absolute timestamp. A cycle with every external source firing at once separates the priority order from arrival order. A held hardware input separates edge from level detection. A second receive strobe fired behind a blocked slot separates slot collision from queue overflow, and a burst of pushes with no pops fills the queue. Fixed trim settings in both modes, with both signs, and then randomly varied trims and sparse random sources with random pops and clears, tell apart the per-clock accumulator from the divided one. They also show whether a carry adds or withholds a count.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  localparam int TYPE_W = 4;

  typedef enum logic [TYPE_W-1:0] {
    EV_HWPUSH  = 4'd0,
    EV_ETH_RX  = 4'd1,
    EV_ETH_TX  = 4'd2,
    EV_HOST_TX = 4'd3,
    EV_SW_PUSH = 4'd4,
    EV_ROLL    = 4'd5,
    EV_HALF    = 4'd6
  } ev_type_e;

  // number of non-hardware event sources after the push inputs
  localparam int N_FIXED_EV = 6;

endpackage

// File: rtl/ts_time_base.sv
module ts_time_base #(
  parameter int CNT_W   = 32,
  parameter int FRAC_W  = 32,
  parameter int PPH_DIV = 3600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trim_pph,
  input  logic              trim_neg,
  input  logic [FRAC_W-1:0] trim_frac,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              roll_o,
  output logic              half_o
);

  localparam int DIV_W = (PPH_DIV > 1) ? $clog2(PPH_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PPH_DIV - 1);

  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              msb_q;
  logic              tick;
  logic              carry;
  logic [FRAC_W:0]   acc_sum;
  logic [1:0]        step;

  always_comb begin
    tick    = !trim_pph || (div_q == DIV_LAST);
    acc_sum = {1'b0, acc_q} + {1'b0, trim_frac};
    carry   = tick && acc_sum[FRAC_W];
    if (!carry)        step = 2'd1;
    else if (trim_neg) step = 2'd0;
    else               step = 2'd2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      msb_q <= 1'b0;
    end else begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      if (tick) acc_q <= acc_sum[FRAC_W-1:0];
      cnt_q <= cnt_q + CNT_W'(step);
      msb_q <= cnt_q[CNT_W-1];
    end
  end

  assign cnt_o  = cnt_q;
  assign roll_o = msb_q & ~cnt_q[CNT_W-1];
  assign half_o = ~msb_q & cnt_q[CNT_W-1];

endmodule

// File: rtl/ts_event_stage.sv
module ts_event_stage #(
  parameter int NUM_EV = 14,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = $clog2(NUM_EV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [CNT_W-1:0]  stamp_i,
  output logic              win_vld_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic [CNT_W-1:0]  win_ts_o,
  output logic              clash_o
);

  logic [NUM_EV-1:0] slot_v;
  logic [CNT_W-1:0]  slot_ts [NUM_EV];
  logic [NUM_EV-1:0] take;
  logic [NUM_EV-1:0] clash;
  logic [NUM_EV-1:0] load;

  // lowest index wins
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_ts_o  = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (slot_v[i]) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        win_ts_o  = slot_ts[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_slot
    assign take[g]  = win_vld_o && (win_idx_o == IDX_W'(g));
    assign load[g]  = ev_i[g] && (!slot_v[g] || take[g]);
    assign clash[g] = ev_i[g] && slot_v[g] && !take[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v <= '0;
    end else begin
      for (int i = 0; i < NUM_EV; i++) begin
        if (load[i])      slot_v[i] <= 1'b1;
        else if (take[i]) slot_v[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_EV; i++) begin
      if (load[i]) slot_ts[i] <= stamp_i;
    end
  end

  assign clash_o = |clash;

endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo #(
  parameter int W     = 39,
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_pop,
  output logic [W-1:0]  rd_data,
  output logic          not_empty,
  output logic          full,
  output logic          wr_done,
  output logic [CW-1:0] count
);

  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_rd;

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign wr_done   = wr_req && !full;
  assign do_rd     = rd_pop && not_empty;

  always_ff @(posedge clk) begin
    if (wr_done) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_done) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd)   rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(wr_done) - CW'(do_rd);
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit #(
  parameter int CNT_W      = 32,
  parameter int FRAC_W     = 32,
  parameter int PPH_DIV    = 3600,
  parameter int NUM_HW     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int SRC_W      = $clog2(NUM_HW)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_HW-1:0]            hw_push_i,
  input  logic                         eth_rx_i,
  input  logic                         eth_tx_i,
  input  logic                         host_tx_i,
  input  logic                         sw_push_i,
  input  logic                         trim_pph_i,
  input  logic                         trim_neg_i,
  input  logic [FRAC_W-1:0]            trim_frac_i,
  input  logic                         rd_pop_i,
  input  logic                         ovf_clr_i,
  output logic                         rd_valid_o,
  output logic [ts_cap_pkg::TYPE_W-1:0] rd_type_o,
  output logic [SRC_W-1:0]             rd_src_o,
  output logic [CNT_W-1:0]             rd_stamp_o,
  output logic                         ovf_o
);

  import ts_cap_pkg::*;

  localparam int NUM_EV  = NUM_HW + N_FIXED_EV;
  localparam int IDX_W   = $clog2(NUM_EV);
  localparam int ENT_W   = TYPE_W + SRC_W + CNT_W;
  localparam int FCNT_W  = $clog2(FIFO_DEPTH + 1);

  logic [CNT_W-1:0]  time_now;
  logic              ev_roll;
  logic              ev_half;
  logic [NUM_HW-1:0] hw_q;
  logic [NUM_EV-1:0] ev_vec;
  logic              win_vld;
  logic [IDX_W-1:0]  win_idx;
  logic [CNT_W-1:0]  win_ts;
  logic              clash;
  logic [TYPE_W-1:0] win_type;
  logic [SRC_W-1:0]  win_src;
  logic [ENT_W-1:0]  head;
  logic              fifo_full;
  logic              fifo_wr;
  logic [FCNT_W-1:0] fifo_cnt;
  logic              drop;
  logic              ovf_q;

  ts_time_base #(
    .CNT_W  (CNT_W),
    .FRAC_W (FRAC_W),
    .PPH_DIV(PPH_DIV)
  ) u_time (
    .clk      (clk),
    .rst      (rst),
    .trim_pph (trim_pph_i),
    .trim_neg (trim_neg_i),
    .trim_frac(trim_frac_i),
    .cnt_o    (time_now),
    .roll_o   (ev_roll),
    .half_o   (ev_half)
  );

  always_ff @(posedge clk) begin
    if (rst) hw_q <= '0;
    else     hw_q <= hw_push_i;
  end

  assign ev_vec = {ev_half, ev_roll, sw_push_i, host_tx_i, eth_tx_i, eth_rx_i,
                   hw_push_i & ~hw_q};

  ts_event_stage #(
    .NUM_EV(NUM_EV),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) u_stage (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (ev_vec),
    .stamp_i  (time_now),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx),
    .win_ts_o (win_ts),
    .clash_o  (clash)
  );

  always_comb begin
    if (win_idx < IDX_W'(NUM_HW)) begin
      win_type = EV_HWPUSH;
      win_src  = SRC_W'(win_idx);
    end else begin
      win_type = TYPE_W'(win_idx - IDX_W'(NUM_HW) + IDX_W'(1));
      win_src  = '0;
    end
  end

  ts_event_fifo #(
    .W    (ENT_W),
    .DEPTH(FIFO_DEPTH),
    .CW   (FCNT_W)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (win_vld),
    .wr_data  ({win_type, win_src, win_ts}),
    .rd_pop   (rd_pop_i),
    .rd_data  (head),
    .not_empty(rd_valid_o),
    .full     (fifo_full),
    .wr_done  (fifo_wr),
    .count    (fifo_cnt)
  );

  assign drop = (win_vld && fifo_full) || clash;

  always_ff @(posedge clk) begin
    if (rst)            ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign ovf_o      = ovf_q;
  assign rd_type_o  = head[ENT_W-1 -: TYPE_W];
  assign rd_src_o   = head[CNT_W +: SRC_W];
  assign rd_stamp_o = head[CNT_W-1:0];

endmodule

// File: rtl/ts_capture_unit_chk.sv
module ts_capture_unit_chk #(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 32,
  parameter int DEPTH  = 16,
  parameter int FCW    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [FRAC_W-1:0] trim_frac_i,
  input logic [CNT_W-1:0]  time_now,
  input logic              ovf_o,
  input logic              ovf_clr_i,
  input logic              rd_valid_o,
  input logic              drop,
  input logic              fifo_wr,
  input logic [FCW-1:0]    fifo_cnt
);

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R1: reset leaves queue empty and flag low
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!rd_valid_o && !ovf_o));

  // R2: no trim, step of one
  p_plain_step_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(trim_frac_i) == '0) |-> (time_now == CNT_W'($past(time_now) + 1'b1)));

  // R3: step never exceeds two and never goes back
  p_step_range_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |-> (CNT_W'(time_now - $past(time_now)) <= CNT_W'(2)));

  // R10, R11: a discard raises the flag
  p_drop_sets_r10: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf_o);

  // R12: flag is sticky without a clear
  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R12: clear without a discard lowers the flag
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr_i && !drop) |=> !ovf_o);

  // R13: empty queue stays empty without a write
  p_empty_pop_r13: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid_o && !fifo_wr) |=> !rd_valid_o);

  // R10: occupancy bound
  p_no_overfill_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= FCW'(DEPTH));

endmodule

bind ts_capture_unit ts_capture_unit_chk #(
  .CNT_W (CNT_W),
  .FRAC_W(FRAC_W),
  .DEPTH (FIFO_DEPTH),
  .FCW   (FCNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .trim_frac_i(trim_frac_i),
  .time_now   (time_now),
  .ovf_o      (ovf_o),
  .ovf_clr_i  (ovf_clr_i),
  .rd_valid_o (rd_valid_o),
  .drop       (drop),
  .fifo_wr    (fifo_wr),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/ts_capture_unit_bench.sv
`timescale 1ns/1ps
module ts_capture_unit_bench;

  localparam int CW  = 12;
  localparam int FW  = 32;
  localparam int DIV = 3600;
  localparam int NHW = 8;
  localparam int DEP = 16;
  localparam int NEV = 14;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NHW-1:0] hw_push = '0;
  logic           eth_rx = 1'b0, eth_tx = 1'b0, host_tx = 1'b0, sw_push = 1'b0;
  logic           trim_pph = 1'b0, trim_neg = 1'b0;
  logic [FW-1:0]  trim_frac = '0;
  logic           rd_pop = 1'b0, ovf_clr = 1'b0;
  logic           rd_valid, ovf;
  logic [3:0]     rd_type;
  logic [2:0]     rd_src;
  logic [CW-1:0]  rd_stamp;

  // trim settings applied at the next drive
  logic           t_pph = 1'b0, t_neg = 1'b0;
  logic [FW-1:0]  t_frac = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ts_capture_unit #(
    .CNT_W(CW), .FRAC_W(FW), .PPH_DIV(DIV), .NUM_HW(NHW), .FIFO_DEPTH(DEP)
  ) u_ts_capture_unit (
    .clk(clk), .rst(rst), .hw_push_i(hw_push), .eth_rx_i(eth_rx),
    .eth_tx_i(eth_tx), .host_tx_i(host_tx), .sw_push_i(sw_push),
    .trim_pph_i(trim_pph), .trim_neg_i(trim_neg), .trim_frac_i(trim_frac),
    .rd_pop_i(rd_pop), .ovf_clr_i(ovf_clr), .rd_valid_o(rd_valid),
    .rd_type_o(rd_type), .rd_src_o(rd_src), .rd_stamp_o(rd_stamp), .ovf_o(ovf)
  );

  // ---------------- reference model ----------------
  int unsigned  m_cnt, m_div;
  logic [31:0]  m_acc;
  bit           m_msb;
  bit [7:0]     m_hwq;
  bit [NEV-1:0] m_sv;
  int unsigned  m_sts [NEV];
  logic [18:0]  m_q [$];
  bit           m_ovf;

  task automatic model_reset();
    m_cnt = 0; m_div = 0; m_acc = '0; m_msb = 0; m_hwq = '0; m_sv = '0;
    m_ovf = 0; m_q.delete();
    for (int i = 0; i < NEV; i++) m_sts[i] = 0;
  endtask

  function automatic logic [18:0] entry(input int idx, input int unsigned ts);
    logic [3:0] ty;
    logic [2:0] sr;
    ty = (idx < 8) ? 4'd0 : 4'(idx - 7);
    sr = (idx < 8) ? 3'(idx) : 3'd0;
    return {ty, sr, 12'(ts)};
  endfunction

  task automatic model_step(input bit [7:0] hw, input bit rx, tx, host, sw,
                            input bit pop, clr, pph, neg, input logic [31:0] frac);
    bit [NEV-1:0] ev;
    int win;
    bit drop, full, tick, carry, tk;
    logic [32:0] sum;
    ev[7:0] = hw & ~m_hwq;
    ev[8] = rx; ev[9] = tx; ev[10] = host; ev[11] = sw;
    ev[12] = m_msb && !m_cnt[CW-1];
    ev[13] = !m_msb && m_cnt[CW-1];
    win = -1;
    for (int i = NEV - 1; i >= 0; i--) if (m_sv[i]) win = i;
    drop = 0;
    full = (m_q.size() == DEP);
    if (win >= 0 && full) drop = 1;
    if (pop && m_q.size() != 0) void'(m_q.pop_front());
    if (win >= 0 && !full) m_q.push_back(entry(win, m_sts[win]));
    for (int i = 0; i < NEV; i++) begin
      tk = (win == i);
      if (ev[i] && m_sv[i] && !tk) drop = 1;
      else if (ev[i]) begin m_sv[i] = 1; m_sts[i] = m_cnt; end
      else if (tk) m_sv[i] = 0;
    end
    if (drop) m_ovf = 1; else if (clr) m_ovf = 0;
    tick  = !pph || (m_div == DIV - 1);
    sum   = {1'b0, m_acc} + {1'b0, frac};
    carry = tick && sum[32];
    if (tick) m_acc = sum[31:0];
    m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
    m_msb = m_cnt[CW-1];
    m_cnt = (m_cnt + (carry ? (neg ? 0 : 2) : 1)) & ((1 << CW) - 1);
    m_hwq = hw;
  endtask

  // ---------------- checks ----------------
  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    chk(tag, "valid", 32'(rd_valid), 32'(m_q.size() != 0));
    chk(tag, "ovf", 32'(ovf), 32'(m_ovf));
    if (m_q.size() != 0) chk(tag, "head", 32'({rd_type, rd_src, rd_stamp}), 32'(m_q[0]));
  endtask

  // drive one cycle at the current negedge, then check at the next
  task automatic cyc(input string tag, input bit [7:0] hw, input bit rx, tx, host,
                     sw, pop, clr);
    hw_push = hw; eth_rx = rx; eth_tx = tx; host_tx = host; sw_push = sw;
    rd_pop = pop; ovf_clr = clr;
    trim_pph = t_pph; trim_neg = t_neg; trim_frac = t_frac;
    model_step(hw, rx, tx, host, sw, pop, clr, t_pph, t_neg, t_frac);
    @(negedge clk);
    cmp_model(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 40; i++) cyc(tag, 8'h00, 0, 0, 0, 0, 1, 0);
  endtask

  int seen_roll = 0, seen_half = 0;

  task automatic run_push(input string tag, input int n, input int period);
    for (int i = 0; i < n; i++) begin
      if (rd_valid && rd_type == 4'd5) seen_roll++;
      if (rd_valid && rd_type == 4'd6) seen_half++;
      cyc(tag, 8'h00, 0, 0, 0, (i % period) == 0, 1, 0);
    end
  endtask

  initial begin
    logic [CW-1:0] base;
    int got;
    void'($urandom(32'd20517));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    chk("R1", "valid after reset", 32'(rd_valid), 32'd0);
    chk("R1", "ovf after reset", 32'(ovf), 32'd0);

    // R2: counter 5 in the sixth cycle after release
    idle("R2", 5);
    cyc("R2", 8'h00, 0, 0, 0, 1, 0, 0);
    idle("R2", 1);
    chk("R2", "first stamp", 32'(rd_stamp), 32'd5);
    chk("R6", "sw type", 32'(rd_type), 32'd4);
    drain("R9");

    // R8: all external sources at once
    cyc("R8", 8'hFF, 1, 1, 1, 1, 0, 0);
    idle("R8", 14);
    base = rd_stamp;
    for (int i = 0; i < 12; i++) begin
      chk("R8", "order type", 32'(rd_type), (i < 8) ? 32'd0 : 32'(i - 7));
      chk("R8", "order src", 32'(rd_src), (i < 8) ? 32'(i) : 32'd0);
      chk("R8", "same stamp", 32'(rd_stamp), 32'(base));
      cyc("R8", 8'h00, 0, 0, 0, 0, 1, 0);
    end
    chk("R9", "empty after 12 pops", 32'(rd_valid), 32'd0);

    // R6: separate cycles
    cyc("R6", 8'h00, 1, 0, 0, 0, 0, 0);
    cyc("R6", 8'h00, 0, 1, 0, 0, 0, 0);
    cyc("R6", 8'h00, 0, 0, 1, 0, 0, 0);
    idle("R6", 3);
    for (int i = 0; i < 3; i++) begin
      chk("R6", "strobe type", 32'(rd_type), 32'(i + 1));
      cyc("R6", 8'h00, 0, 0, 0, 0, 1, 0);
    end

    // R5: held input gives one capture
    for (int i = 0; i < 6; i++) cyc("R5", 8'h08, 0, 0, 0, 0, 0, 0);
    idle("R5", 3);
    chk("R5", "held type", 32'(rd_type), 32'd0);
    chk("R5", "held src", 32'(rd_src), 32'd3);
    cyc("R5", 8'h00, 0, 0, 0, 0, 1, 0);
    chk("R5", "single capture", 32'(rd_valid), 32'd0);

    // R11: receive fires again while its slot waits
    cyc("R11", 8'hFF, 1, 0, 0, 0, 0, 0);
    cyc("R11", 8'h00, 1, 0, 0, 0, 0, 0);
    chk("R11", "collision flag", 32'(ovf), 32'd1);
    idle("R11", 12);
    got = 0;
    for (int i = 0; i < 12; i++) begin
      if (rd_valid) got++;
      cyc("R11", 8'h00, 0, 0, 0, 0, 1, 0);
    end
    chk("R11", "entries kept", 32'(got), 32'd9);
    chk("R12", "sticky", 32'(ovf), 32'd1);
    cyc("R12", 8'h00, 0, 0, 0, 0, 0, 1);
    chk("R12", "cleared", 32'(ovf), 32'd0);

    // R13: pops on empty
    for (int i = 0; i < 3; i++) cyc("R13", 8'h00, 0, 0, 0, 0, 1, 0);
    chk("R13", "still empty", 32'(rd_valid), 32'd0);
    cyc("R13", 8'h00, 0, 0, 0, 1, 0, 0);
    idle("R13", 1);
    chk("R13", "write after pops", 32'(rd_valid), 32'd1);
    drain("R13");

    // R10: fill the queue
    for (int i = 0; i < 20; i++) cyc("R10", 8'h00, 0, 0, 0, 1, 0, 0);
    idle("R10", 2);
    chk("R10", "full flag", 32'(ovf), 32'd1);
    got = 0;
    for (int i = 0; i < 20; i++) begin
      if (rd_valid) got++;
      cyc("R10", 8'h00, 0, 0, 0, 0, 1, 0);
    end
    chk("R10", "depth", 32'(got), 32'(DEP));
    cyc("R12", 8'h00, 0, 0, 0, 0, 0, 1);

    // R3: per-clock trim, both signs
    t_pph = 0; t_neg = 0; t_frac = 32'h4000_0000;
    run_push("R3", 3000, 37);
    t_neg = 1; t_frac = 32'h9000_0000;
    run_push("R3", 3000, 41);
    // R7: rollover and half-rollover seen during the run
    t_neg = 0; t_frac = '0;
    run_push("R7", 4200, 53);
    chk("R7", "rollover seen", 32'(seen_roll > 0), 32'd1);
    chk("R7", "half seen", 32'(seen_half > 0), 32'd1);

    // R4: divided trim
    t_pph = 1; t_neg = 0; t_frac = 32'hC000_0000;
    run_push("R4", 15000, 29);
    t_neg = 1;
    run_push("R4", 15000, 31);

    // random mix
    for (int blk = 0; blk < 20; blk++) begin
      t_pph = 1'($urandom); t_neg = 1'($urandom); t_frac = $urandom;
      for (int i = 0; i < 1500; i++) begin
        cyc("R9", 8'($urandom & $urandom & $urandom & $urandom),
            ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
            ($urandom % 16) == 0, ($urandom % 4) != 0, ($urandom % 64) == 0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule